// File: doc/BRIEF.md
# Cascadable LCD Segment Line Capture

This block gathers the display data for one line of a dot-matrix segment driver with 320 outputs. Data groups arrive on a bus that is 4 or 8 bits wide. Each falling edge of the capture clock stores one group at the position the internal pointer marks, and the pointer then advances. The block starts filling only after its active-low enable input has gone low. When the last group is stored, it drives its own enable output low, which passes the token to the next chip in a cascade. A falling edge of the line clock rearms the block for the next line.

A direction input sets the fill order and swaps the two enable pins. With the input high, the line fills from position 0 upward, enable pin 1 is the input and pin 2 is the output. With the input low, the line fills from position 319 downward and the pins trade roles. Both clocks are ordinary synchronous inputs. An edge detector in the block finds their falling edges, sampled on the system clock.

The sequencer has three named states:
- **WAIT_EN**: waiting for the token.
- **FILLING**: storing groups.
- **HANDOFF**: line full, enable output low.

It has four named transitions:
- **start**: WAIT_EN→FILLING, on a capture edge while the enable input is low.
- **finish**: FILLING→HANDOFF (or straight from WAIT_EN), on the capture edge that stores the last group.
- **rearm**: any state→WAIT_EN, on a line-clock falling edge.
- **hold**: every other case keeps the current state.

Top module: `lcd_seg_capture`

## Requirements
- R1: After reset, `line_data` is all zeros, both enable outputs are high with output-enable low, and the block waits for the token.
- R2: In WAIT_EN, capture-clock falling edges while the active enable input is high store nothing, and the pointer does not move.
- R3: With `bus8`=0, each capture falling edge stores `data_in[3:0]` into 4 positions, and `data_in[7:4]` is ignored. A line takes 80 edges.
- R4: With `bus8`=1, each capture falling edge stores all 8 bits into 8 positions. A line takes 40 edges.
- R5: With `shl`=1, the group stored on edge k (counting from 0) has base B=4k in 4-bit mode or B=8k in 8-bit mode, and bit i goes to `line_data[B+i]`.
- R6: With `shl`=0, the same group places bit i at `line_data[319-B-i]`.
- R7: With `shl`=1, `eio1_in` is the enable input and `eio2_out`/`eio2_oe` drive the output. With `shl`=0 the roles swap. The pin acting as input has out=1 and oe=0.
- R8: The enable output goes low in the system clock cycle after the falling edge that stores the last group is detected. Before that edge it stays high.
- R9: In HANDOFF, further capture falling edges change neither `line_data` nor the enable output.
- R10: A line-clock falling edge returns the block to WAIT_EN with the pointer at 0 and the enable output high. `line_data` keeps its contents, and the next line fills again from the first position.
- R11: When line-clock and capture-clock falling edges are detected in the same cycle, the line clock wins and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_clk | input | 1 | Capture clock; falling edge stores a group |
| line_clk | input | 1 | Line clock; falling edge rearms the block |
| data_in | input | 8 | Display data group |
| bus8 | input | 1 | 1 = 8-bit groups, 0 = 4-bit groups |
| shl | input | 1 | Direction: 1 = ascending fill, 0 = descending fill |
| eio1_in | input | 1 | Enable pin 1, input side (active low) |
| eio1_out | output | 1 | Enable pin 1, output value |
| eio1_oe | output | 1 | Enable pin 1, output enable |
| eio2_in | input | 1 | Enable pin 2, input side (active low) |
| eio2_out | output | 1 | Enable pin 2, output value |
| eio2_oe | output | 1 | Enable pin 2, output enable |
| line_data | output | 320 | Captured line contents |

## Verification
The assertions assume that `bus8` and `shl` stay constant for the whole of a line. They also assume that both clock inputs are already synchronous to `clk` and stay low or high for at least one system cycle. The stimulus changes configuration only right after a line-clock edge. It drives every clock level on a falling system-clock edge and holds each level for two cycles. Each of the four bus-width and direction combinations is swept over a whole line of arithmetically generated data.

// File: rtl/seg_pkg.sv
package seg_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_EN = 2'd0,
        ST_FILLING = 2'd1,
        ST_HANDOFF = 2'd2
    } seg_state_t;
endpackage

// File: rtl/seg_edge_detect.sv
module seg_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= level_in;
    end

    assign fall = prev_q & ~level_in;

    // R2: one falling edge produces exactly one strobe cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/seg_fill_fsm.sv
module seg_fill_fsm
    import seg_pkg::*;
#(
    parameter int SLOTS = 80,
    parameter int PTR_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_fall,
    input  logic             line_fall,
    input  logic             en_in_n,
    input  logic             bus8,
    output logic             strobe,
    output logic [PTR_W-1:0] ptr,
    output logic             done
);
    seg_state_t       state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic [PTR_W:0]   ptr_sum;
    logic             go;

    assign ptr_sum = {1'b0, ptr_q} + (bus8 ? (PTR_W+1)'(2) : (PTR_W+1)'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_EN;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        go      = 1'b0;
        if (line_fall) begin
            state_d = ST_WAIT_EN;
            ptr_d   = '0;
        end else begin
            unique case (state_q)
                ST_WAIT_EN: go = cap_fall & ~en_in_n;
                ST_FILLING: go = cap_fall;
                ST_HANDOFF: go = 1'b0;
                default:    go = 1'b0;
            endcase
            if (go) begin
                ptr_d   = ptr_sum[PTR_W-1:0];
                state_d = (ptr_sum >= (PTR_W+1)'(SLOTS)) ? ST_HANDOFF : ST_FILLING;
            end
        end
    end

    always_comb begin
        strobe = go;
        ptr    = ptr_q;
        done   = (state_q == ST_HANDOFF);
    end

    // R10: rearm returns the pointer to the start and releases the token
    a_r10_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        line_fall |=> (ptr == '0 && !done));
    // R9: the handoff state holds until rearmed
    a_r9_hold_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !line_fall) |=> (done && $stable(ptr)));
    // R3: pointer never runs past the line
    a_r3_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PTR_W'(SLOTS));
    // R8: handoff is only entered with the full line stored
    a_r8_full_on_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ptr == PTR_W'(SLOTS));
    // R2: without the token the block stays parked at the start
    a_r2_wait_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_EN && en_in_n && !line_fall) |=>
            (state_q == ST_WAIT_EN && ptr == '0));
endmodule

// File: rtl/seg_group_store.sv
module seg_group_store #(
    parameter int NUM_POS = 320,
    parameter int NIB     = 4,
    parameter int SLOTS   = NUM_POS / NIB,
    parameter int PTR_W   = $clog2(SLOTS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe,
    input  logic [PTR_W-1:0]   ptr,
    input  logic               shl,
    input  logic               bus8,
    input  logic [2*NIB-1:0]   data_in,
    output logic [NUM_POS-1:0] line_q
);
    int phys_lo, phys_hi;
    logic [NIB-1:0] nib_lo, nib_hi;

    function automatic logic [NIB-1:0] orient(input logic [NIB-1:0] n, input logic asc);
        logic [NIB-1:0] r;
        for (int i = 0; i < NIB; i++) r[i] = asc ? n[i] : n[NIB-1-i];
        return r;
    endfunction

    always_comb begin
        phys_lo = shl ? int'(ptr)     : SLOTS - 1 - int'(ptr);
        phys_hi = shl ? int'(ptr) + 1 : SLOTS - 2 - int'(ptr);
        nib_lo  = orient(data_in[NIB-1:0], shl);
        nib_hi  = orient(data_in[2*NIB-1:NIB], shl);
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q[s*NIB +: NIB] <= '0;
            end else if (strobe) begin
                if (phys_lo == s)
                    line_q[s*NIB +: NIB] <= nib_lo;
                else if (bus8 && phys_hi == s)
                    line_q[s*NIB +: NIB] <= nib_hi;
            end
        end
    end

    // R9: contents only move on a capture strobe
    a_r9_store_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(line_q));
endmodule

// File: rtl/seg_enable_route.sv
module seg_enable_route (
    input  logic shl,
    input  logic done,
    input  logic eio1_in,
    input  logic eio2_in,
    output logic en_in_n,
    output logic eio1_out,
    output logic eio1_oe,
    output logic eio2_out,
    output logic eio2_oe
);
    always_comb begin
        en_in_n  = shl ? eio1_in : eio2_in;
        eio1_oe  = ~shl;
        eio2_oe  = shl;
        eio1_out = shl ? 1'b1 : ~done;
        eio2_out = shl ? ~done : 1'b1;
    end
endmodule

// File: rtl/lcd_seg_capture.sv
module lcd_seg_capture #(
    parameter int NUM_POS = 320,
    parameter int BUS_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_clk,
    input  logic               line_clk,
    input  logic [BUS_W-1:0]   data_in,
    input  logic               bus8,
    input  logic               shl,
    input  logic               eio1_in,
    output logic               eio1_out,
    output logic               eio1_oe,
    input  logic               eio2_in,
    output logic               eio2_out,
    output logic               eio2_oe,
    output logic [NUM_POS-1:0] line_data
);
    localparam int NIB   = BUS_W / 2;
    localparam int SLOTS = NUM_POS / NIB;
    localparam int PTR_W = $clog2(SLOTS + 1);

    logic             cap_fall, line_fall, en_in_n, strobe, done;
    logic [PTR_W-1:0] ptr;

    seg_edge_detect u_cap_edge (
        .clk(clk), .rst_n(rst_n), .level_in(cap_clk), .fall(cap_fall));
    seg_edge_detect u_line_edge (
        .clk(clk), .rst_n(rst_n), .level_in(line_clk), .fall(line_fall));

    seg_enable_route u_route (
        .shl(shl), .done(done), .eio1_in(eio1_in), .eio2_in(eio2_in),
        .en_in_n(en_in_n), .eio1_out(eio1_out), .eio1_oe(eio1_oe),
        .eio2_out(eio2_out), .eio2_oe(eio2_oe));

    seg_fill_fsm #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cap_fall(cap_fall), .line_fall(line_fall),
        .en_in_n(en_in_n), .bus8(bus8), .strobe(strobe), .ptr(ptr), .done(done));

    seg_group_store #(.NUM_POS(NUM_POS), .NIB(NIB), .SLOTS(SLOTS), .PTR_W(PTR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .ptr(ptr), .shl(shl),
        .bus8(bus8), .data_in(data_in), .line_q(line_data));

    // R7: the pin acting as input is never driven low
    a_r7_input_pin_released: assert property (@(posedge clk) disable iff (!rst_n)
        (shl ? (eio1_out && !eio1_oe) : (eio2_out && !eio2_oe)));
    // R11: a line-clock edge blocks any store in the same cycle
    a_r11_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
        line_fall |=> $stable(line_data));
endmodule

// File: tb/tb_lcd_seg_capture.sv
module tb_lcd_seg_capture;
    localparam int NP = 320;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_clk = 1'b1, line_clk = 1'b1;
    logic [7:0]    data_in = '0;
    logic          bus8 = 1'b0, shl = 1'b1;
    logic          eio1_in = 1'b0, eio2_in = 1'b1;
    logic          eio1_out, eio1_oe, eio2_out, eio2_oe;
    logic [NP-1:0] line_data;
    logic [NP-1:0] exp_line = '0;
    int            checks = 0, failures = 0;

    always #2 clk = ~clk;

    lcd_seg_capture dut (
        .clk(clk), .rst_n(rst_n), .cap_clk(cap_clk), .line_clk(line_clk),
        .data_in(data_in), .bus8(bus8), .shl(shl),
        .eio1_in(eio1_in), .eio1_out(eio1_out), .eio1_oe(eio1_oe),
        .eio2_in(eio2_in), .eio2_out(eio2_out), .eio2_oe(eio2_oe),
        .line_data(line_data));

    task automatic check(input bit ok, input string req,
                         input logic [NP-1:0] act, input logic [NP-1:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic en_out_pin();
        return shl ? eio2_out : eio1_out;
    endfunction

    task automatic set_token(input logic active);
        eio1_in = shl ? ~active : 1'b1;
        eio2_in = shl ? 1'b1 : ~active;
    endtask

    task automatic cap_pulse(input logic [7:0] b);
        @(negedge clk); data_in = b; cap_clk = 1'b0;
        @(negedge clk);
        @(negedge clk); cap_clk = 1'b1;
        @(negedge clk);
    endtask

    task automatic line_pulse();
        @(negedge clk); line_clk = 1'b0;
        @(negedge clk);
        @(negedge clk); line_clk = 1'b1;
        @(negedge clk);
    endtask

    task automatic model_store(input int k, input logic [7:0] b);
        int w, base, l;
        w    = bus8 ? 8 : 4;
        base = k * w;
        for (int i = 0; i < w; i++) begin
            l = base + i;
            exp_line[shl ? l : NP - 1 - l] = b[i];
        end
    endtask

    task automatic run_line(input int seed);
        int steps;
        logic [7:0] b;
        steps = bus8 ? 40 : 80;
        set_token(1'b1);
        for (int k = 0; k < steps; k++) begin
            b = 8'(k * 29 + seed * 13 + 7);
            if (!bus8) b[7:4] = ~b[3:0];
            model_store(k, b);
            cap_pulse(b);
            if (k == steps - 2)
                check(en_out_pin() == 1'b1, "R8 token held before last group",
                      NP'(en_out_pin()), NP'(1));
        end
        check(line_data == exp_line,
              bus8 ? (shl ? "R4 R5 8-bit ascending" : "R4 R6 8-bit descending")
                   : (shl ? "R3 R5 4-bit ascending" : "R3 R6 4-bit descending"),
              line_data, exp_line);
        check(en_out_pin() == 1'b0, "R8 token passed", NP'(en_out_pin()), NP'(0));
        check(shl ? (eio1_out && !eio1_oe && eio2_oe) : (eio2_out && !eio2_oe && eio1_oe),
              "R7 pin roles", NP'({eio1_out, eio1_oe, eio2_out, eio2_oe}), NP'(0));
        cap_pulse(8'hA5);
        cap_pulse(8'h3C);
        check(line_data == exp_line, "R9 edges ignored after handoff", line_data, exp_line);
        check(en_out_pin() == 1'b0, "R9 token stays low", NP'(en_out_pin()), NP'(0));
        line_pulse();
        check(en_out_pin() == 1'b1, "R10 rearm releases token", NP'(en_out_pin()), NP'(1));
        check(line_data == exp_line, "R10 contents retained", line_data, exp_line);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(line_data == '0, "R1 reset data", line_data, '0);
        check(eio1_out && eio2_out && eio2_oe && !eio1_oe, "R1 reset enables",
              NP'({eio1_out, eio1_oe, eio2_out, eio2_oe}), NP'(4'b1011));

        // R2: no token on the active input (only on the other pin) -> nothing stored
        eio1_in = 1'b1; eio2_in = 1'b0;
        cap_pulse(8'hFF);
        cap_pulse(8'h81);
        check(line_data == exp_line, "R2 no capture without token", line_data, exp_line);
        check(eio2_out == 1'b1, "R2 token not passed", NP'(eio2_out), NP'(1));

        for (int s = 1; s >= 0; s--) begin
            for (int m = 0; m < 2; m++) begin
                @(negedge clk);
                shl  = s[0];
                bus8 = m[0];
                run_line(s * 2 + m + 1);
            end
        end

        // R11: simultaneous line and capture edges, line wins
        shl = 1'b1; bus8 = 1'b1; set_token(1'b1);
        @(negedge clk); data_in = 8'h5A; cap_clk = 1'b0; line_clk = 1'b0;
        @(negedge clk);
        @(negedge clk); cap_clk = 1'b1; line_clk = 1'b1;
        @(negedge clk);
        check(line_data == exp_line, "R11 line edge wins", line_data, exp_line);
        check(eio2_out == 1'b1, "R11 token high", NP'(eio2_out), NP'(1));
        // R10: next line still starts from position 0
        run_line(9);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule